// File: doc/BRIEF.md
# Punctured Convolutional Viterbi Decoder

This block recovers the information bits from a hard-decision stream that was produced by a rate-1/2 convolutional encoder with constraint length 7 and then thinned out by puncturing. The encoder taps are 171 and 133 in octal. Each accepted input cycle carries the two code bits of one trellis step. The two bits are called X (taps 171) and Y (taps 133). Each bit has an erasure flag from upstream.

A depuncturing stage follows the repeating keep/drop pattern of the configured rate. It marks dropped positions as erased, so they add nothing to any branch metric. Kept positions add their Hamming distance. An add-compare-select array over the 64 trellis states keeps one survivor path per state, and each path is 128 steps long. Every step, the oldest bit of the path belonging to the lowest-metric state is released. Decoded bits leave in their original order and are later packed into bytes ahead of de-interleaving and Reed-Solomon correction.

The rate is set by a configuration input. It should only be changed while no input is flowing.

Top module: `punct_viterbi_dec`

## Requirements
- R1: At rate code 0 (rate 1/2, every X and Y kept), an error-free stream decodes to exactly the encoded information bits, in order.
- R2: Rate codes 1..5 select rates 2/3, 3/4, 5/6, 6/7, 7/8. The kept positions per phase, listed as X;Y from phase 0, are 10;11, 101;110, 10101;11010, 100101;111010 and 1000101;1111010. Each rate decodes error-free streams exactly.
- R3: The pattern phase is 0 after reset and advances only on accepted pairs (in_valid high). It wraps to 0 after the last phase of the pattern, so idle cycles between pairs do not disturb decoding.
- R4: The value presented at a position that the pattern drops has no effect on the decoded output.
- R5: A position whose erasure flag (in_era_x or in_era_y) is high adds nothing to the metric, so a wrong value there does not change the output.
- R6: Isolated channel bit errors, one every 20 steps at rate 1/2, are corrected.
- R7: Each accepted pair beyond the 128th (index j ≥ 128, counting from 0 after reset) makes out_valid high for one cycle, two rising edges after it was accepted. out_bit then carries information bit j−128. No other cycle has out_valid high, so a stream of N pairs yields N−128 bits.
- R8: After reset, out_valid is low. State 0 has metric 0, every other state a large bias, and all survivor paths are cleared, so a new stream decodes correctly after any earlier activity.
- R9: The lowest path metric never reaches half the metric range. Once any metric reaches half the range, the minimum is subtracted from all of them, and decoding stays correct across this.
- R10: Rate codes 6 and 7 behave as rate code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_rate | input | 3 | Rate code (0:1/2, 1:2/3, 2:3/4, 3:5/6, 4:6/7, 5:7/8, other:1/2) |
| in_valid | input | 1 | A code-bit pair is presented this cycle |
| in_x | input | 1 | Received bit of the 171 output |
| in_y | input | 1 | Received bit of the 133 output |
| in_era_x | input | 1 | Treat in_x as erased |
| in_era_y | input | 1 | Treat in_y as erased |
| out_valid | output | 1 | out_bit holds a decoded bit this cycle |
| out_bit | output | 1 | Decoded information bit |

## Verification
An accepted pair passes one register in the depuncturer. On the next edge it updates the survivor array and the output register together. The decoded bit therefore shows two edges after acceptance, and it belongs to the pair accepted 128 steps earlier. The bench drives stimulus and samples on the falling edge, and it records the edge count at which pair 128 was accepted. The first out_valid is expected exactly one edge after that record. After each stream, the bench waits a few idle cycles, then compares the number of emitted bits with N−128 and compares every emitted bit in order with the stored information bits.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int CONSTR_LEN = 7;
  localparam logic [CONSTR_LEN-1:0] GEN_X = 7'o171;
  localparam logic [CONSTR_LEN-1:0] GEN_Y = 7'o133;

  typedef enum logic [2:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_6_7 = 3'd4,
    RATE_7_8 = 3'd5
  } rate_e;

  // Number of trellis steps in one puncturing cycle.
  function automatic logic [2:0] punct_period(input logic [2:0] code);
    case (code)
      RATE_2_3: return 3'd2;
      RATE_3_4: return 3'd3;
      RATE_5_6: return 3'd5;
      RATE_6_7: return 3'd6;
      RATE_7_8: return 3'd7;
      default:  return 3'd1;
    endcase
  endfunction

  // Returns {keep_x, keep_y} for a phase; bit p of each mask is phase p.
  function automatic logic [1:0] punct_keep(input logic [2:0] code, input logic [2:0] ph);
    logic [7:0] mx;
    logic [7:0] my;
    case (code)
      RATE_2_3: begin mx = 8'b0000_0001; my = 8'b0000_0011; end
      RATE_3_4: begin mx = 8'b0000_0101; my = 8'b0000_0011; end
      RATE_5_6: begin mx = 8'b0001_0101; my = 8'b0000_1011; end
      RATE_6_7: begin mx = 8'b0010_1001; my = 8'b0001_0111; end
      RATE_7_8: begin mx = 8'b0101_0001; my = 8'b0010_1111; end
      default:  begin mx = 8'b0000_0001; my = 8'b0000_0001; end
    endcase
    return {mx[ph], my[ph]};
  endfunction

  // Encoder outputs {x, y} for register contents {newest input, state}.
  function automatic logic [1:0] branch_code(input logic [CONSTR_LEN-1:0] sr);
    return {^(sr & GEN_X), ^(sr & GEN_Y)};
  endfunction
endpackage

// File: rtl/vit_depunct.sv
module vit_depunct
  import vit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_rate,
  input  logic       in_valid,
  input  logic       in_x,
  input  logic       in_y,
  input  logic       in_era_x,
  input  logic       in_era_y,
  output logic       dp_valid,
  output logic       dp_x,
  output logic       dp_y,
  output logic       dp_use_x,
  output logic       dp_use_y,
  output logic [2:0] dp_phase,
  output logic [2:0] dp_period
);
  logic [2:0] phase_q, phase_d;
  logic [1:0] keep;
  logic       valid_q, x_q, y_q, ux_q, uy_q;

  always_comb begin
    dp_period = punct_period(cfg_rate);
    keep      = punct_keep(cfg_rate, phase_q);
    phase_d   = phase_q;
    if (in_valid) begin
      phase_d = (phase_q >= dp_period - 3'd1) ? 3'd0 : phase_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 3'd0;
      valid_q <= 1'b0;
      x_q     <= 1'b0;
      y_q     <= 1'b0;
      ux_q    <= 1'b0;
      uy_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        phase_q <= phase_d;
        x_q     <= in_x;
        y_q     <= in_y;
        ux_q    <= keep[1] & ~in_era_x;
        uy_q    <= keep[0] & ~in_era_y;
      end
    end
  end

  assign dp_valid = valid_q;
  assign dp_x     = x_q;
  assign dp_y     = y_q;
  assign dp_use_x = ux_q;
  assign dp_use_y = uy_q;
  assign dp_phase = phase_q;
endmodule

// File: rtl/vit_minfind.sv
module vit_minfind #(
  parameter int NS  = 64,
  parameter int PMW = 8,
  localparam int SW = $clog2(NS)
) (
  input  logic [PMW-1:0] metric [NS],
  output logic [SW-1:0]  best_idx,
  output logic [PMW-1:0] min_val,
  output logic           any_high
);
  always_comb begin
    best_idx = '0;
    min_val  = metric[0];
    any_high = metric[0][PMW-1];
    for (int i = 1; i < NS; i++) begin
      any_high = any_high | metric[i][PMW-1];
      if (metric[i] < min_val) begin
        min_val  = metric[i];
        best_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_pkg::*;
#(
  parameter int PMW   = 8,
  parameter int DEPTH = 128,
  localparam int SW   = CONSTR_LEN - 1,
  localparam int NS   = 1 << SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           bx,
  input  logic           by,
  input  logic           use_x,
  input  logic           use_y,
  output logic           best_bit,
  output logic [PMW-1:0] min_metric
);
  localparam logic [PMW-1:0] INIT_BIAS = PMW'(1 << (PMW - 2));

  logic [PMW-1:0]   metric_q [NS];
  logic [PMW-1:0]   metric_d [NS];
  logic [DEPTH-1:0] path_q   [NS];
  logic [DEPTH-1:0] path_d   [NS];
  logic [SW-1:0]    best_idx;
  logic             any_high;

  vit_minfind #(.NS(NS), .PMW(PMW)) u_min (
    .metric  (metric_q),
    .best_idx(best_idx),
    .min_val (min_metric),
    .any_high(any_high)
  );

  for (genvar n = 0; n < NS; n++) begin : g_state
    localparam int            P0I = (n * 2) % NS;
    localparam logic [SW-1:0] P0  = SW'(P0I);
    localparam logic [SW-1:0] P1  = SW'(P0I + 1);
    localparam logic          U   = 1'((n >> (SW - 1)) & 1);
    localparam logic [1:0]    C0  = branch_code({U, P0});
    localparam logic [1:0]    C1  = branch_code({U, P1});

    logic [1:0]     bm0, bm1;
    logic [PMW-1:0] cand0, cand1, surv;
    logic           sel;

    always_comb begin
      bm0   = {1'b0, use_x & (bx ^ C0[1])} + {1'b0, use_y & (by ^ C0[0])};
      bm1   = {1'b0, use_x & (bx ^ C1[1])} + {1'b0, use_y & (by ^ C1[0])};
      cand0 = metric_q[P0] + PMW'(bm0);
      cand1 = metric_q[P1] + PMW'(bm1);
      sel   = cand1 < cand0;
      surv  = sel ? cand1 : cand0;
      metric_d[n] = any_high ? surv - min_metric : surv;
      path_d[n]   = {sel ? path_q[P1][DEPTH-2:0] : path_q[P0][DEPTH-2:0], U};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        metric_q[i] <= (i == 0) ? '0 : INIT_BIAS;
        path_q[i]   <= '0;
      end
    end else if (step) begin
      for (int i = 0; i < NS; i++) begin
        metric_q[i] <= metric_d[i];
        path_q[i]   <= path_d[i];
      end
    end
  end

  assign best_bit = path_q[best_idx][DEPTH-1];
endmodule

// File: rtl/punct_viterbi_dec.sv
module punct_viterbi_dec #(
  parameter int TB_DEPTH = 128,
  parameter int PM_W     = 8,
  localparam int CW      = $clog2(TB_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_rate,
  input  logic       in_valid,
  input  logic       in_x,
  input  logic       in_y,
  input  logic       in_era_x,
  input  logic       in_era_y,
  output logic       out_valid,
  output logic       out_bit
);
  logic            dp_valid, dp_x, dp_y, dp_use_x, dp_use_y;
  logic [2:0]      dp_phase, dp_period;
  logic            best_bit;
  logic [PM_W-1:0] min_metric;
  logic [CW-1:0]   fill_q, fill_d;
  logic            ov_q, ov_d, ob_q, ob_d;

  vit_depunct u_dep (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_era_x(in_era_x), .in_era_y(in_era_y),
    .dp_valid(dp_valid), .dp_x(dp_x), .dp_y(dp_y),
    .dp_use_x(dp_use_x), .dp_use_y(dp_use_y),
    .dp_phase(dp_phase), .dp_period(dp_period)
  );

  vit_acs_array #(.PMW(PM_W), .DEPTH(TB_DEPTH)) u_acs (
    .clk(clk), .rst_n(rst_n), .step(dp_valid),
    .bx(dp_x), .by(dp_y), .use_x(dp_use_x), .use_y(dp_use_y),
    .best_bit(best_bit), .min_metric(min_metric)
  );

  always_comb begin
    fill_d = fill_q;
    if (dp_valid && fill_q != CW'(TB_DEPTH)) fill_d = fill_q + CW'(1);
    ov_d = dp_valid && (fill_q == CW'(TB_DEPTH));
    ob_d = dp_valid ? best_bit : ob_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else begin
      fill_q <= fill_d;
      ov_q   <= ov_d;
      ob_q   <= ob_d;
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;
endmodule

// File: rtl/vit_chk.sv
module vit_chk #(
  parameter int DEPTH = 128,
  parameter int PMW   = 8,
  localparam int AW   = $clog2(DEPTH + 2)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     cfg_rate,
  input logic           in_valid,
  input logic           out_valid,
  input logic [PMW-1:0] min_metric,
  input logic [2:0]     phase,
  input logic [2:0]     period
);
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (in_valid && acc_q != AW'(DEPTH + 1)) acc_q <= acc_q + AW'(1);
  end

  // R7: an output is due two edges after an accepted pair
  p_out_after_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R7, R8: nothing leaves before more than DEPTH pairs were accepted
  p_fill_before_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q >= AW'(DEPTH + 1)));

  // R9: normalisation keeps the best metric below half range
  p_metric_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !min_metric[PMW-1]);

  // R3: phase stays inside the pattern
  p_phase_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase < period);

  // R3: idle cycles leave the phase alone
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $stable(cfg_rate)) |=> $stable(phase));
endmodule

bind punct_viterbi_dec vit_chk #(.DEPTH(TB_DEPTH), .PMW(PM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .in_valid(in_valid),
  .out_valid(out_valid), .min_metric(min_metric),
  .phase(dp_phase), .period(dp_period)
);

// File: tb/punct_viterbi_dec_tb.sv
module punct_viterbi_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int MAXN       = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_x = 1'b0, in_y = 1'b0, in_era_x = 1'b0, in_era_y = 1'b0;
  logic       out_valid, out_bit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int out_idx = 0;
  int mism = 0;
  int first_out = -1;
  int acc_d = -1;
  int n_cur = 0;
  logic info [MAXN];

  punct_viterbi_dec #(.TB_DEPTH(DEPTH), .PM_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .in_valid(in_valid),
    .in_x(in_x), .in_y(in_y), .in_era_x(in_era_x), .in_era_y(in_era_y),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (first_out < 0) first_out = cyc;
      if (out_idx >= n_cur || out_idx >= MAXN) mism++;
      else if (out_bit !== info[out_idx]) mism++;
      out_idx++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pattern from the requirement tables: bit p = phase p kept.
  function automatic int bench_period(input int pat);
    case (pat)
      1: return 2; 2: return 3; 3: return 5; 4: return 6; 5: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic logic bench_keep(input int pat, input int ph, input bit is_y);
    logic [6:0] mx, my;
    case (pat)
      1: begin mx = 7'b0000001; my = 7'b0000011; end
      2: begin mx = 7'b0000101; my = 7'b0000011; end
      3: begin mx = 7'b0010101; my = 7'b0001011; end
      4: begin mx = 7'b0101001; my = 7'b0010111; end
      5: begin mx = 7'b1010001; my = 7'b0101111; end
      default: begin mx = 7'b0000001; my = 7'b0000001; end
    endcase
    return is_y ? my[ph] : mx[ph];
  endfunction

  task automatic do_reset(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req, "out_valid after reset", int'(out_valid), 0);
  endtask

  // One stream: cfg code, pattern used to encode, length, error spacing,
  // dropped-position inversion, idle gap, erasure spacing.
  task automatic run_stream(input string req, input logic [2:0] code, input int pat,
                            input int n, input int err_every, input bit flip_drop,
                            input int gap, input int era_every, input int seed);
    logic [15:0] lfsr;
    logic [5:0]  st;
    logic [6:0]  sr;
    logic        u, cx, cy, tx, ty, ex, ey;
    int          ph;
    do_reset("R8");
    cfg_rate = code;
    out_idx = 0; mism = 0; first_out = -1; acc_d = -1; n_cur = n;
    lfsr = 16'(seed) | 16'h0001;
    st = '0;
    for (int j = 0; j < n; j++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      u = lfsr[0];
      info[j] = u;
      sr = {u, st};
      cx = ^(sr & 7'o171);
      cy = ^(sr & 7'o133);
      st = {u, st[5:1]};
      ph = j % bench_period(pat);
      tx = cx; ty = cy; ex = 1'b0; ey = 1'b0;
      if (!bench_keep(pat, ph, 1'b0)) tx = flip_drop ? ~cx : 1'b0;
      if (!bench_keep(pat, ph, 1'b1)) ty = flip_drop ? ~cy : 1'b0;
      if (err_every > 0 && (j % err_every) == err_every / 2) ty = ~ty;
      if (era_every > 0 && (j % era_every) == 3) begin ex = 1'b1; tx = ~tx; end
      if (era_every > 0 && (j % era_every) == 5) begin ey = 1'b1; ty = ~ty; end
      in_valid = 1'b1; in_x = tx; in_y = ty; in_era_x = ex; in_era_y = ey;
      @(negedge clk);
      if (j == DEPTH) acc_d = cyc;
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0; in_era_x = 1'b0; in_era_y = 1'b0;
    repeat (6) @(negedge clk);
    chk(req, "decoded bit mismatches", mism, 0);
    chk("R7", "number of decoded bits", out_idx, n - DEPTH);
    chk("R7", "edge of first output", first_out, acc_d + 1);
  endtask

  task automatic t_rate_half;       run_stream("R1", 3'd0, 0, 600, 0, 1'b0, 0, 0, 16'h1ace); endtask
  task automatic t_rates_punct;
    run_stream("R2", 3'd1, 1, 600, 0, 1'b0, 0, 0, 16'h2bcd);
    run_stream("R2", 3'd2, 2, 600, 0, 1'b0, 0, 0, 16'h3e21);
    run_stream("R2", 3'd3, 3, 600, 0, 1'b0, 0, 0, 16'h4f77);
    run_stream("R2", 3'd4, 4, 600, 0, 1'b0, 0, 0, 16'h5a5a);
    run_stream("R2", 3'd5, 5, 700, 0, 1'b0, 0, 0, 16'h6c3b);
  endtask
  task automatic t_gaps;
    run_stream("R3", 3'd2, 2, 400, 0, 1'b0, 2, 0, 16'h7101);
    run_stream("R3", 3'd5, 5, 400, 0, 1'b0, 1, 0, 16'h7202);
  endtask
  task automatic t_dropped_ignored;
    run_stream("R4", 3'd2, 2, 600, 0, 1'b1, 0, 0, 16'h8d13);
    run_stream("R4", 3'd5, 5, 600, 0, 1'b1, 0, 0, 16'h8e24);
  endtask
  task automatic t_erasure;         run_stream("R5", 3'd0, 0, 600, 0, 1'b0, 0, 11, 16'h9311); endtask
  task automatic t_errors_norm;
    run_stream("R6", 3'd0, 0, 3200, 20, 1'b0, 0, 0, 16'ha7e5);
    chk("R9", "metric normalisation over long noisy stream", mism, 0);
  endtask
  task automatic t_bad_codes;
    run_stream("R10", 3'd6, 0, 500, 0, 1'b0, 0, 0, 16'hb0b0);
    run_stream("R10", 3'd7, 0, 500, 0, 1'b0, 0, 0, 16'hc1c1);
  endtask

  initial begin
    t_rate_half();
    t_rates_punct();
    t_gaps();
    t_dropped_ignored();
    t_erasure();
    t_errors_norm();
    t_bad_codes();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule